// File: doc/BRIEF.md
# Stereo and Second-Program Identification with Output Route Selection

This block sits between the level detectors of a television sound decoder and its output switching. Three quantised measurements arrive together on a strobe: the stereo pilot level, the second-program (SAP) carrier level and the composite noise level. From these the block keeps two hysteretic reception flags, one for stereo and one for SAP. Each flag is cleared whenever the composite noise rises above a limit chosen by its own 4-bit threshold code.

The two flags are combined with the listener's mode bits (`sel_stereo`, `sel_sap`) and two forced-mute bits. The result is three registered 2-bit route codes: one for the left output, one for the right output, and one for the separate SAP output. The audio path uses these codes to pick its sources. The flags themselves are also exported, so a register interface can read them back.

Top module: `bcast_id_router`

## Requirements
- R1: While `rst` is high, and on the first clock after it, both flags read 0 and all three route codes read 0 (mute).
- R2: With `pilot_hi_sel`=1, a strobe sets the stereo flag when the pilot code is above 35 and clears it when the code is below 15. Codes from 15 to 35 leave the flag unchanged.
- R3: With `pilot_hi_sel`=0, a strobe sets the stereo flag when the pilot code is above 30 and clears it when the code is below 10. Codes from 10 to 30 leave the flag unchanged.
- R4: A strobe sets the SAP flag when the carrier code is above 68 and clears it when the code is below 28. Codes from 28 to 68 leave the flag unchanged.
- R5: A strobe whose noise code is above T(`st_noise_code`) clears the stereo flag whatever the pilot level is. A noise code equal to T(n) does not clear it. T(n) is computed by starting from v=24·256, repeating v=floor(v·304/256) n times, and then taking floor(v/256). This gives 24 for code 0, 40 for code 3, 47 for code 4 and 315 for code 15.
- R6: The SAP flag is cleared in the same way when the noise code is above T(`sap_noise_code`). Each flag is gated by its own code, independently of the other.
- R7: The flags change only on the clock edge where `lvl_valid` is 1. Level changes without the strobe have no effect.
- R8: Route codes are 0 mute, 1 mono, 2 own channel (left on the left output, right on the right output) and 3 SAP. `route_sap` is 3 when the SAP flag is set and 0 otherwise.
- R9: With `sel_stereo`=1 and `sel_sap`=1, both main routes are 3 when the SAP flag is set and 0 otherwise.
- R10: With `sel_stereo`=1 and `sel_sap`=0, both main routes are 2 when the stereo flag is set and 1 otherwise.
- R11: With `sel_stereo`=0 and `sel_sap`=1, `route_l` is 1. `route_r` is 3 when the SAP flag is set and 0 otherwise.
- R12: With `sel_stereo`=0 and `sel_sap`=0, both main routes are 1 whatever the flags are.
- R13: `mute_main`=1 forces `route_l` and `route_r` to 0, and `mute_sap`=1 forces `route_sap` to 0. These override R8 to R12.
- R14: The route codes are registered. They reflect the flags and control bits present at the previous clock edge and never change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_valid | input | 1 | Strobe: the level codes are valid this cycle |
| pilot_lvl | input | 8 | Stereo pilot level, 1 mV per LSB |
| sapcar_lvl | input | 8 | SAP carrier level, 1 mV per LSB |
| noise_lvl | input | 9 | Composite noise level, 1 mV per LSB |
| sel_stereo | input | 1 | Mode bit requesting stereo |
| sel_sap | input | 1 | Mode bit requesting second program |
| pilot_hi_sel | input | 1 | Selects the higher pilot threshold pair |
| mute_main | input | 1 | Forced mute of both main outputs |
| mute_sap | input | 1 | Forced mute of the separate SAP output |
| st_noise_code | input | 4 | Noise limit code for stereo identification |
| sap_noise_code | input | 4 | Noise limit code for SAP identification |
| stereo_det | output | 1 | Stereo-received flag |
| sap_det | output | 1 | SAP-received flag |
| route_l | output | 2 | Left output route code |
| route_r | output | 2 | Right output route code |
| route_sap | output | 2 | Separate SAP output route code |

## Verification
Each hysteresis band is walked across both of its edges: the value one above and one below every on and off limit. This shows the difference between a correct strict comparison and an inclusive one, and shows that the flag holds inside the band. Noise is applied at exactly the threshold and one code above it. This is done for codes 0, 3, 4 and 15, with different codes on the two flags, which shows that each flag is gated only by its own table entry. All four flag combinations are crossed with all four mode settings. This catches any swapped or mis-keyed route entry. Finally, mode bits are changed between edges to show that the routes change only at the following clock edge.

// File: rtl/bid_pkg.sv
package bid_pkg;

  typedef enum logic [1:0] {
    RT_MUTE = 2'd0,
    RT_MONO = 2'd1,
    RT_CHAN = 2'd2,
    RT_SAP  = 2'd3
  } route_e;

  // Geometric threshold ladder in Q8: each step multiplies by mul_q8/256.
  function automatic int noise_step_value(input int idx, input int base, input int mul_q8);
    int v;
    v = base * 256;
    for (int k = 0; k < idx; k++) begin
      v = (v * mul_q8) / 256;
    end
    return v / 256;
  endfunction

endpackage

// File: rtl/noise_thr_lut.sv
module noise_thr_lut #(
  parameter int CODE_W  = 4,
  parameter int NOISE_W = 9,
  parameter int BASE_MV = 24,
  parameter int STEP_Q8 = 304
) (
  input  logic [CODE_W-1:0]  code,
  output logic [NOISE_W-1:0] limit
);
  import bid_pkg::*;

  localparam int ENTRIES = 1 << CODE_W;

  logic [NOISE_W-1:0] table_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_step
    assign table_q[g] = NOISE_W'(noise_step_value(g, BASE_MV, STEP_Q8));
  end

  assign limit = table_q[code];

endmodule

// File: rtl/id_hyst.sv
module id_hyst #(
  parameter int LVL_W   = 8,
  parameter int NOISE_W = 9,
  parameter int ON_A    = 35,
  parameter int OFF_A   = 15,
  parameter int ON_B    = 30,
  parameter int OFF_B   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd,
  input  logic               sel_a,
  input  logic [LVL_W-1:0]   lvl,
  input  logic [NOISE_W-1:0] noise,
  input  logic [NOISE_W-1:0] noise_lim,
  output logic               det
);
  localparam logic [LVL_W-1:0] ON_A_L  = LVL_W'(ON_A);
  localparam logic [LVL_W-1:0] OFF_A_L = LVL_W'(OFF_A);
  localparam logic [LVL_W-1:0] ON_B_L  = LVL_W'(ON_B);
  localparam logic [LVL_W-1:0] OFF_B_L = LVL_W'(OFF_B);

  logic [LVL_W-1:0] on_lim;
  logic [LVL_W-1:0] off_lim;
  logic             noisy;

  always_comb begin
    on_lim  = sel_a ? ON_A_L  : ON_B_L;
    off_lim = sel_a ? OFF_A_L : OFF_B_L;
    noisy   = noise > noise_lim;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det <= 1'b0;
    end else if (upd) begin
      if (noisy)              det <= 1'b0;
      else if (lvl > on_lim)  det <= 1'b1;
      else if (lvl < off_lim) det <= 1'b0;
    end
  end

endmodule

// File: rtl/route_dec.sv
module route_dec (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_stereo,
  input  logic       sel_sap,
  input  logic       mute_main,
  input  logic       mute_sap,
  input  logic       st_det,
  input  logic       sap_det,
  output logic [1:0] route_l,
  output logic [1:0] route_r,
  output logic [1:0] route_sap
);
  import bid_pkg::*;

  route_e l_nx, r_nx, s_nx;
  route_e sap_or_mute;

  always_comb begin
    sap_or_mute = sap_det ? RT_SAP : RT_MUTE;
    unique case ({sel_stereo, sel_sap})
      2'b11: begin l_nx = sap_or_mute; r_nx = sap_or_mute; end
      2'b10: begin
        l_nx = st_det ? RT_CHAN : RT_MONO;
        r_nx = st_det ? RT_CHAN : RT_MONO;
      end
      2'b01: begin l_nx = RT_MONO; r_nx = sap_or_mute; end
      default: begin l_nx = RT_MONO; r_nx = RT_MONO; end
    endcase
    if (mute_main) begin
      l_nx = RT_MUTE;
      r_nx = RT_MUTE;
    end
    s_nx = mute_sap ? RT_MUTE : sap_or_mute;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_l   <= RT_MUTE;
      route_r   <= RT_MUTE;
      route_sap <= RT_MUTE;
    end else begin
      route_l   <= l_nx;
      route_r   <= r_nx;
      route_sap <= s_nx;
    end
  end

endmodule

// File: rtl/bcast_id_router.sv
module bcast_id_router #(
  parameter int LVL_W       = 8,
  parameter int NOISE_W     = 9,
  parameter int CODE_W      = 4,
  parameter int ST_ON_HI    = 35,
  parameter int ST_OFF_HI   = 15,
  parameter int ST_ON_LO    = 30,
  parameter int ST_OFF_LO   = 10,
  parameter int SAP_ON      = 68,
  parameter int SAP_OFF     = 28,
  parameter int THR_BASE    = 24,
  parameter int THR_STEP_Q8 = 304
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lvl_valid,
  input  logic [LVL_W-1:0]   pilot_lvl,
  input  logic [LVL_W-1:0]   sapcar_lvl,
  input  logic [NOISE_W-1:0] noise_lvl,
  input  logic               sel_stereo,
  input  logic               sel_sap,
  input  logic               pilot_hi_sel,
  input  logic               mute_main,
  input  logic               mute_sap,
  input  logic [CODE_W-1:0]  st_noise_code,
  input  logic [CODE_W-1:0]  sap_noise_code,
  output logic               stereo_det,
  output logic               sap_det,
  output logic [1:0]         route_l,
  output logic [1:0]         route_r,
  output logic [1:0]         route_sap
);

  logic [NOISE_W-1:0] st_thr;
  logic [NOISE_W-1:0] sap_thr;

  noise_thr_lut #(.CODE_W(CODE_W), .NOISE_W(NOISE_W), .BASE_MV(THR_BASE), .STEP_Q8(THR_STEP_Q8))
    u_st_lut (.code(st_noise_code), .limit(st_thr));

  noise_thr_lut #(.CODE_W(CODE_W), .NOISE_W(NOISE_W), .BASE_MV(THR_BASE), .STEP_Q8(THR_STEP_Q8))
    u_sap_lut (.code(sap_noise_code), .limit(sap_thr));

  id_hyst #(.LVL_W(LVL_W), .NOISE_W(NOISE_W),
            .ON_A(ST_ON_HI), .OFF_A(ST_OFF_HI), .ON_B(ST_ON_LO), .OFF_B(ST_OFF_LO))
    u_st_id (.clk(clk), .rst(rst), .upd(lvl_valid), .sel_a(pilot_hi_sel),
             .lvl(pilot_lvl), .noise(noise_lvl), .noise_lim(st_thr), .det(stereo_det));

  id_hyst #(.LVL_W(LVL_W), .NOISE_W(NOISE_W),
            .ON_A(SAP_ON), .OFF_A(SAP_OFF), .ON_B(SAP_ON), .OFF_B(SAP_OFF))
    u_sap_id (.clk(clk), .rst(rst), .upd(lvl_valid), .sel_a(1'b1),
              .lvl(sapcar_lvl), .noise(noise_lvl), .noise_lim(sap_thr), .det(sap_det));

  route_dec u_route (
    .clk(clk), .rst(rst), .sel_stereo(sel_stereo), .sel_sap(sel_sap),
    .mute_main(mute_main), .mute_sap(mute_sap), .st_det(stereo_det), .sap_det(sap_det),
    .route_l(route_l), .route_r(route_r), .route_sap(route_sap)
  );

endmodule

// File: rtl/bid_checks.sv
module bid_checks #(
  parameter int LVL_W    = 8,
  parameter int NOISE_W  = 9,
  parameter int ST_ON_HI = 35,
  parameter int SAP_OFF  = 28
) (
  input logic               clk,
  input logic               rst,
  input logic               lvl_valid,
  input logic [LVL_W-1:0]   pilot_lvl,
  input logic [LVL_W-1:0]   sapcar_lvl,
  input logic [NOISE_W-1:0] noise_lvl,
  input logic               sel_stereo,
  input logic               sel_sap,
  input logic               pilot_hi_sel,
  input logic               mute_main,
  input logic               mute_sap,
  input logic               stereo_det,
  input logic               sap_det,
  input logic [1:0]         route_l,
  input logic [1:0]         route_r,
  input logic [1:0]         route_sap,
  input logic [NOISE_W-1:0] st_thr,
  input logic [NOISE_W-1:0] sap_thr
);
  localparam logic [LVL_W-1:0] ST_ON_L   = LVL_W'(ST_ON_HI);
  localparam logic [LVL_W-1:0] SAP_OFF_L = LVL_W'(SAP_OFF);

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !lvl_valid |=> ($stable(stereo_det) && $stable(sap_det)));

  assert_st_noise_R5: assert property (@(posedge clk) disable iff (rst)
    (lvl_valid && noise_lvl > st_thr) |=> !stereo_det);

  assert_sap_noise_R6: assert property (@(posedge clk) disable iff (rst)
    (lvl_valid && noise_lvl > sap_thr) |=> !sap_det);

  assert_st_on_R2: assert property (@(posedge clk) disable iff (rst)
    (lvl_valid && pilot_hi_sel && noise_lvl <= st_thr && pilot_lvl > ST_ON_L) |=> stereo_det);

  assert_sap_off_R4: assert property (@(posedge clk) disable iff (rst)
    (lvl_valid && sapcar_lvl < SAP_OFF_L) |=> !sap_det);

  assert_mode_stereo_R10: assert property (@(posedge clk) disable iff (rst)
    (sel_stereo && !sel_sap && !mute_main && stereo_det) |=> (route_l == 2'd2 && route_r == 2'd2));

  assert_mode_left_mono_R11: assert property (@(posedge clk) disable iff (rst)
    (!sel_stereo && sel_sap && !mute_main) |=> (route_l == 2'd1));

  assert_mode_mono_R12: assert property (@(posedge clk) disable iff (rst)
    (!sel_stereo && !sel_sap && !mute_main) |=> (route_l == 2'd1 && route_r == 2'd1));

  assert_mute_main_R13: assert property (@(posedge clk) disable iff (rst)
    mute_main |=> (route_l == 2'd0 && route_r == 2'd0));

  assert_mute_sap_R13: assert property (@(posedge clk) disable iff (rst)
    mute_sap |=> (route_sap == 2'd0));

endmodule

bind bcast_id_router bid_checks #(
  .LVL_W(LVL_W), .NOISE_W(NOISE_W), .ST_ON_HI(ST_ON_HI), .SAP_OFF(SAP_OFF)
) u_bid_checks (
  .clk(clk), .rst(rst), .lvl_valid(lvl_valid), .pilot_lvl(pilot_lvl),
  .sapcar_lvl(sapcar_lvl), .noise_lvl(noise_lvl), .sel_stereo(sel_stereo),
  .sel_sap(sel_sap), .pilot_hi_sel(pilot_hi_sel), .mute_main(mute_main),
  .mute_sap(mute_sap), .stereo_det(stereo_det), .sap_det(sap_det),
  .route_l(route_l), .route_r(route_r), .route_sap(route_sap),
  .st_thr(st_thr), .sap_thr(sap_thr)
);

// File: tb/tb_bcast_id_router.sv
module tb_bcast_id_router;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lvl_valid = 1'b0;
  logic [7:0] pilot_lvl = '0;
  logic [7:0] sapcar_lvl = '0;
  logic [8:0] noise_lvl = '0;
  logic       sel_stereo = 1'b0;
  logic       sel_sap = 1'b0;
  logic       pilot_hi_sel = 1'b1;
  logic       mute_main = 1'b0;
  logic       mute_sap = 1'b0;
  logic [3:0] st_noise_code = 4'd15;
  logic [3:0] sap_noise_code = 4'd15;
  logic       stereo_det, sap_det;
  logic [1:0] route_l, route_r, route_sap;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcast_id_router dut (
    .clk(clk), .rst(rst), .lvl_valid(lvl_valid), .pilot_lvl(pilot_lvl),
    .sapcar_lvl(sapcar_lvl), .noise_lvl(noise_lvl), .sel_stereo(sel_stereo),
    .sel_sap(sel_sap), .pilot_hi_sel(pilot_hi_sel), .mute_main(mute_main),
    .mute_sap(mute_sap), .st_noise_code(st_noise_code), .sap_noise_code(sap_noise_code),
    .stereo_det(stereo_det), .sap_det(sap_det),
    .route_l(route_l), .route_r(route_r), .route_sap(route_sap)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Threshold ladder as stated in R5
  function automatic int thr_of(input int n);
    int v = 24 * 256;
    for (int k = 0; k < n; k++) v = (v * 304) / 256;
    return v / 256;
  endfunction

  // Expected {route_l, route_r} from R9..R13
  function automatic logic [3:0] exp_main(input bit st, input bit sp, input bit stf,
                                          input bit spf, input bit mm);
    logic [1:0] l, r;
    if (st && sp)       begin l = spf ? 2'd3 : 2'd0; r = l; end
    else if (st)        begin l = stf ? 2'd2 : 2'd1; r = l; end
    else if (sp)        begin l = 2'd1; r = spf ? 2'd3 : 2'd0; end
    else                begin l = 2'd1; r = 2'd1; end
    if (mm) begin l = 2'd0; r = 2'd0; end
    return {l, r};
  endfunction

  // One strobe; returns at the negedge after the flag-updating edge
  task automatic pulse(input int p, input int s, input int n);
    @(negedge clk);
    pilot_lvl = 8'(p); sapcar_lvl = 8'(s); noise_lvl = 9'(n); lvl_valid = 1'b1;
    @(negedge clk);
    lvl_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 stereo_det in reset", stereo_det, 0);
    chk("R1 sap_det in reset", sap_det, 0);
    chk("R1 route_l in reset", route_l, 0);
    chk("R1 route_sap in reset", route_sap, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 default mode route_l", route_l, 1);
    chk("R12 default mode route_r", route_r, 1);
    chk("R8 route_sap no sap", route_sap, 0);
  endtask

  task automatic t_st_hyst_hi;
    pilot_hi_sel = 1'b1;
    pulse(0, 0, 0);
    pulse(35, 0, 0);  chk("R2 pilot 35 stays off", stereo_det, 0);
    pulse(36, 0, 0);  chk("R2 pilot 36 turns on", stereo_det, 1);
    pulse(20, 0, 0);  chk("R2 pilot 20 holds", stereo_det, 1);
    pulse(15, 0, 0);  chk("R2 pilot 15 holds", stereo_det, 1);
    pulse(14, 0, 0);  chk("R2 pilot 14 turns off", stereo_det, 0);
    pulse(30, 0, 0);  chk("R2 pilot 30 below hi-on", stereo_det, 0);
  endtask

  task automatic t_st_hyst_lo;
    pilot_hi_sel = 1'b0;
    pulse(0, 0, 0);
    pulse(30, 0, 0);  chk("R3 pilot 30 stays off", stereo_det, 0);
    pulse(31, 0, 0);  chk("R3 pilot 31 turns on", stereo_det, 1);
    pulse(14, 0, 0);  chk("R3 pilot 14 holds", stereo_det, 1);
    pulse(10, 0, 0);  chk("R3 pilot 10 holds", stereo_det, 1);
    pulse(9, 0, 0);   chk("R3 pilot 9 turns off", stereo_det, 0);
    pilot_hi_sel = 1'b1;
  endtask

  task automatic t_sap_hyst;
    pulse(0, 0, 0);
    pulse(0, 68, 0);  chk("R4 carrier 68 stays off", sap_det, 0);
    pulse(0, 69, 0);  chk("R4 carrier 69 turns on", sap_det, 1);
    pulse(0, 28, 0);  chk("R4 carrier 28 holds", sap_det, 1);
    pulse(0, 27, 0);  chk("R4 carrier 27 turns off", sap_det, 0);
  endtask

  task automatic t_strobe;
    pulse(0, 0, 0);
    @(negedge clk);
    pilot_lvl = 8'd60; sapcar_lvl = 8'd100;
    repeat (3) @(negedge clk);
    chk("R7 stereo ignores level without strobe", stereo_det, 0);
    chk("R7 sap ignores level without strobe", sap_det, 0);
    pulse(60, 100, 0);
    chk("R7 stereo follows strobe", stereo_det, 1);
    chk("R7 sap follows strobe", sap_det, 1);
  endtask

  task automatic t_noise;
    pulse(0, 0, 0);
    st_noise_code = 4'd3; sap_noise_code = 4'd0;
    pulse(50, 0, thr_of(3));      chk("R5 noise at T(3) keeps stereo", stereo_det, 1);
    pulse(50, 0, thr_of(3) + 1);  chk("R5 noise above T(3) clears stereo", stereo_det, 0);
    st_noise_code = 4'd15; sap_noise_code = 4'd4;
    pulse(50, 100, thr_of(4));    chk("R6 noise at T(4) keeps sap", sap_det, 1);
    chk("R5 stereo on under code 15", stereo_det, 1);
    pulse(50, 100, thr_of(4) + 1);
    chk("R6 noise above T(4) clears sap", sap_det, 0);
    chk("R6 stereo unaffected by sap code", stereo_det, 1);
    pulse(50, 100, thr_of(15));   chk("R5 noise at T(15) keeps stereo", stereo_det, 1);
    pulse(50, 100, thr_of(15) + 1); chk("R5 noise above T(15) clears stereo", stereo_det, 0);
    st_noise_code = 4'd0;
    pulse(50, 100, thr_of(0));    chk("R5 noise at T(0) allows stereo", stereo_det, 1);
    pulse(50, 100, thr_of(0) + 1); chk("R5 noise above T(0) clears stereo", stereo_det, 0);
    st_noise_code = 4'd15; sap_noise_code = 4'd15;
  endtask

  task automatic t_modes;
    for (int c = 0; c < 4; c++) begin
      bit stf = c[0];
      bit spf = c[1];
      pulse(stf ? 50 : 0, spf ? 100 : 0, 0);
      for (int m = 0; m < 4; m++) begin
        logic [3:0] e;
        sel_stereo = m[1]; sel_sap = m[0];
        @(negedge clk);
        e = exp_main(m[1], m[0], stf, spf, 1'b0);
        chk($sformatf("R%0d mode %0d flags %0d route_l", 12 - m, m, c), route_l, e[3:2]);
        chk($sformatf("R%0d mode %0d flags %0d route_r", 12 - m, m, c), route_r, e[1:0]);
        chk("R8 route_sap follows sap flag", route_sap, spf ? 3 : 0);
      end
    end
  endtask

  task automatic t_mutes;
    pulse(50, 100, 0);
    sel_stereo = 1'b1; sel_sap = 1'b0; mute_main = 1'b1;
    @(negedge clk);
    chk("R13 mute_main route_l", route_l, 0);
    chk("R13 mute_main route_r", route_r, 0);
    chk("R13 sap output not muted by mute_main", route_sap, 3);
    mute_sap = 1'b1;
    @(negedge clk);
    chk("R13 mute_sap route_sap", route_sap, 0);
    mute_main = 1'b0; mute_sap = 1'b0;
    @(negedge clk);
    chk("R13 released route_l", route_l, 2);
    chk("R13 released route_sap", route_sap, 3);
  endtask

  task automatic t_registered;
    sel_stereo = 1'b1; sel_sap = 1'b0;
    @(negedge clk);
    chk("R14 settled channel", route_l, 2);
    sel_stereo = 1'b0;
    #1;
    chk("R14 no change before edge", route_l, 2);
    chk("R14 no change before edge r", route_r, 2);
    @(negedge clk);
    chk("R14 changed after edge", route_r, 1);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset stereo_det", stereo_det, 0);
    chk("R1 mid reset sap_det", sap_det, 0);
    chk("R1 mid reset route_r", route_r, 0);
    chk("R1 mid reset route_sap", route_sap, 0);
    rst = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    t_reset();
    t_st_hyst_hi();
    t_st_hyst_lo();
    t_sap_hyst();
    t_strobe();
    t_noise();
    t_modes();
    t_mutes();
    t_registered();
    t_reset_mid();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule